// File: doc/BRIEF.md
# Cascadable Compare-Match Timer

This block is a 16-bit up-counter made of two 8-bit halves. It is paired with a 16-bit compare register and drives one compare output pin. The counter advances once for each count-enable pulse from an outside prescaler, and only while a run bit is set. An 8-bit register port lets software load the counter bytes, the compare bytes and a control register. The control register holds the run bit and an output-level bit. Writing that level bit puts its value straight onto the compare pin.

A compare match is signalled on the count pulse that takes the counter away from the compare value. It is not signalled when the counter first reaches that value. Each full 16-bit match toggles the compare pin. Four sticky flags record the events: full match, low-byte match, full overflow and low-byte overflow. Software clears a flag by reading it as 1 and then writing 0 to it.

The block follows fixed rules when a software write and a hardware event fall in the same cycle:
- A control write sets the pin level, and a toggle in that cycle is lost.
- A write to the low compare byte suppresses the match in that cycle.
- A write to the low counter byte suppresses the overflow in that cycle.
- A hardware flag set wins over a flag clear.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter reads 0, the compare register reads 0xFFFF, the control register and all flags read 0, and the compare pin is 0.
- R2: The register map is 0 counter low byte, 1 counter high byte, 2 compare low byte, 3 compare high byte, 4 control (bit0 output level, bit1 run), 5 flags. A write is taken on the clock edge where bus_wr is high, and reads are combinational on bus_addr. While run is 1, each cycle with cnt_tick high adds one to the counter, wrapping from 0xFFFF to 0. With cnt_tick low, the counter holds.
- R3: A full match happens on a counted tick in which the counter equals the compare value, so it is seen as the counter leaves that value. It sets flags bit3 on that clock edge. The tick that brings the counter up to the compare value sets nothing.
- R4: Each full match toggles cmp_pin on the same edge.
- R5: A control write loads cmp_pin with data bit0 on that edge. This holds even when a full match happens in that cycle, and then no toggle takes place.
- R6: A write to the compare low byte in a cycle with a would-be match suppresses both match flags and the toggle for that cycle. A later equality with the new value still matches.
- R7: A counted tick in which the counter's low byte equals the compare low byte sets flags bit2, whatever the high bytes are.
- R8: A counted tick at low byte 0xFF sets flags bit0. A counted tick at 0xFFFF sets flags bit0 and bit1.
- R9: A write to the counter low byte wins over a tick in the same cycle. The low byte takes the written value, the high byte does not carry, and no overflow flag is set.
- R10: Flags are sticky. Writing 0 to a flag bit clears it only if a read of address 5 with bus_rd high has earlier seen that bit as 1. A hardware set in the same cycle as the clear keeps the bit at 1.
- R11: cmp_pin_lo stays at 0 at all times.
- R12: While run is 0, ticks neither move the counter nor produce a match, even when the counter equals the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count-enable pulse from the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cmp_pin | output | 1 | Toggling compare output |
| cmp_pin_lo | output | 1 | Low-byte compare output, held at 0 |

## Verification
Directed sequences walk the counter onto and off a compare value one tick at a time. This separates a match taken on arrival from one taken on departure. The same sequences repeat the walk with run cleared, which shows that a stopped counter cannot match. Single-cycle collisions are then staged: a control, compare-low, counter-low or flag write lands exactly on a match or overflow tick, so that each priority rule shows up as a distinct pin or flag value. A long constrained-random phase follows. It biases write data toward 0x00, 0xFF and small values, so that low-byte wraps, partial matches and read-then-clear races come up often, and a bench model built from the requirements checks every register and pin after each cycle.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] REG_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] REG_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] REG_CMP_LO = 3'd2;
  localparam logic [ADDR_W-1:0] REG_CMP_HI = 3'd3;
  localparam logic [ADDR_W-1:0] REG_CTRL   = 3'd4;
  localparam logic [ADDR_W-1:0] REG_FLAG   = 3'd5;

  localparam int unsigned FLAG_N     = 4;
  localparam int unsigned FLG_OVF_LO = 0;
  localparam int unsigned FLG_OVF_HI = 1;
  localparam int unsigned FLG_CMF_LO = 2;
  localparam int unsigned FLG_CMF_HI = 3;

  localparam int unsigned CTL_LEVEL = 0;
  localparam int unsigned CTL_RUN   = 1;

  typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int unsigned HALF_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wr_data,
  output logic [2*HALF_W-1:0] cnt_q,
  output logic                ovf_lo_evt,
  output logic                ovf_hi_evt
);
  localparam int unsigned FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] cnt_d;

  function automatic logic [FULL_W-1:0] f_advance(input logic [FULL_W-1:0] c, input logic s);
    return c + {{(FULL_W-1){1'b0}}, s};
  endfunction

  function automatic logic f_low_at_top(input logic [FULL_W-1:0] c);
    return &c[HALF_W-1:0];
  endfunction

  function automatic logic f_high_at_top(input logic [FULL_W-1:0] c);
    return &c[FULL_W-1:HALF_W];
  endfunction

  always_comb begin
    ovf_lo_evt = step && f_low_at_top(cnt_q) && !wr_lo;
    ovf_hi_evt = ovf_lo_evt && f_high_at_top(cnt_q);
    cnt_d      = f_advance(cnt_q, step);
    if (wr_lo) begin
      cnt_d[HALF_W-1:0]      = wr_data;
      cnt_d[FULL_W-1:HALF_W] = cnt_q[FULL_W-1:HALF_W];
    end
    if (wr_hi) cnt_d[FULL_W-1:HALF_W] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: a counted tick with no byte write advances by exactly one
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_lo && !wr_hi) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R2: without a tick or write the counter holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_lo && !wr_hi) |=> $stable(cnt_q));

  // R9: a low-byte write wins over a tick and blocks the carry
  a_r9_lo_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> (cnt_q[HALF_W-1:0] == $past(wr_data)) &&
                          (cnt_q[FULL_W-1:HALF_W] == $past(cnt_q[FULL_W-1:HALF_W])));
endmodule

// File: rtl/cmt_compare.sv
module cmt_compare #(
  parameter int unsigned HALF_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic [2*HALF_W-1:0] cnt,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wr_data,
  output logic [2*HALF_W-1:0] cmp_q,
  output logic                match_full,
  output logic                match_low
);
  localparam int unsigned FULL_W = 2 * HALF_W;

  function automatic logic f_eq_low(input logic [FULL_W-1:0] a, input logic [FULL_W-1:0] b);
    return a[HALF_W-1:0] == b[HALF_W-1:0];
  endfunction

  function automatic logic f_eq_high(input logic [FULL_W-1:0] a, input logic [FULL_W-1:0] b);
    return a[FULL_W-1:HALF_W] == b[FULL_W-1:HALF_W];
  endfunction

  always_comb begin
    match_low  = step && f_eq_low(cnt, cmp_q) && !wr_lo;
    match_full = match_low && f_eq_high(cnt, cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
    end else begin
      if (wr_lo) cmp_q[HALF_W-1:0]      <= wr_data;
      if (wr_hi) cmp_q[FULL_W-1:HALF_W] <= wr_data;
    end
  end

  // R6: compare bytes load on write and otherwise hold
  a_r6_cmp_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cmp_q[HALF_W-1:0] == $past(wr_data));

  a_r6_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !wr_hi) |=> $stable(cmp_q));
endmodule

// File: rtl/cmt_flags.sv
module cmt_flags
  import cmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_evt,
  input  logic      rd_arm,
  input  logic      wr_clr,
  input  flag_vec_t wr_bits,
  output flag_vec_t flags_q
);
  flag_vec_t armed_q;
  flag_vec_t clr_vec;

  function automatic flag_vec_t f_update(input flag_vec_t cur, input flag_vec_t set_v,
                                         input flag_vec_t clr_v);
    return set_v | (cur & ~clr_v);
  endfunction

  assign clr_vec = wr_clr ? (armed_q & ~wr_bits) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      armed_q <= '0;
    end else begin
      flags_q <= f_update(flags_q, set_evt, clr_vec);
      if (wr_clr)      armed_q <= '0;
      else if (rd_arm) armed_q <= flags_q;
    end
  end

  for (genvar g = 0; g < FLAG_N; g++) begin : g_chk
    // R10: a hardware set always lands, even against a clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[g] |=> flags_q[g]);
    // R10: a flag never drops without a flag-register write
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[g] && !wr_clr) |=> flags_q[g]);
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmt_pkg::*;
#(
  parameter int unsigned HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              cmp_pin,
  output logic              cmp_pin_lo
);
  localparam int unsigned FULL_W = 2 * HALF_W;

  logic              run_q, level_q, pin_q;
  logic              step;
  logic              wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi, wr_ctrl, wr_flag, rd_flag;
  logic [FULL_W-1:0] cnt_q, cmp_q;
  logic              ovf_lo_evt, ovf_hi_evt, match_full, match_low;
  flag_vec_t         set_evt, flags_q;

  function automatic logic f_sel(input logic strobe, input logic [2:0] a, input logic [2:0] r);
    return strobe && (a == r);
  endfunction

  assign step      = cnt_tick && run_q;
  assign wr_cnt_lo = f_sel(bus_wr, bus_addr, REG_CNT_LO);
  assign wr_cnt_hi = f_sel(bus_wr, bus_addr, REG_CNT_HI);
  assign wr_cmp_lo = f_sel(bus_wr, bus_addr, REG_CMP_LO);
  assign wr_cmp_hi = f_sel(bus_wr, bus_addr, REG_CMP_HI);
  assign wr_ctrl   = f_sel(bus_wr, bus_addr, REG_CTRL);
  assign wr_flag   = f_sel(bus_wr, bus_addr, REG_FLAG);
  assign rd_flag   = f_sel(bus_rd, bus_addr, REG_FLAG);

  cmt_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .wr_lo(wr_cnt_lo), .wr_hi(wr_cnt_hi),
    .wr_data(bus_wdata), .cnt_q(cnt_q), .ovf_lo_evt(ovf_lo_evt), .ovf_hi_evt(ovf_hi_evt)
  );

  cmt_compare #(.HALF_W(HALF_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .step(step), .cnt(cnt_q), .wr_lo(wr_cmp_lo), .wr_hi(wr_cmp_hi),
    .wr_data(bus_wdata), .cmp_q(cmp_q), .match_full(match_full), .match_low(match_low)
  );

  always_comb begin
    set_evt             = '0;
    set_evt[FLG_OVF_LO] = ovf_lo_evt;
    set_evt[FLG_OVF_HI] = ovf_hi_evt;
    set_evt[FLG_CMF_LO] = match_low;
    set_evt[FLG_CMF_HI] = match_full;
  end

  cmt_flags u_flg (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .rd_arm(rd_flag), .wr_clr(wr_flag),
    .wr_bits(bus_wdata[FLAG_N-1:0]), .flags_q(flags_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      level_q <= 1'b0;
      pin_q   <= 1'b0;
    end else if (wr_ctrl) begin
      run_q   <= bus_wdata[CTL_RUN];
      level_q <= bus_wdata[CTL_LEVEL];
      pin_q   <= bus_wdata[CTL_LEVEL];
    end else if (match_full) begin
      pin_q   <= ~pin_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CNT_LO: bus_rdata = cnt_q[HALF_W-1:0];
      REG_CNT_HI: bus_rdata = cnt_q[FULL_W-1:HALF_W];
      REG_CMP_LO: bus_rdata = cmp_q[HALF_W-1:0];
      REG_CMP_HI: bus_rdata = cmp_q[FULL_W-1:HALF_W];
      REG_CTRL:   bus_rdata = HALF_W'({run_q, level_q});
      REG_FLAG:   bus_rdata = HALF_W'(flags_q);
      default:    bus_rdata = '0;
    endcase
  end

  assign cmp_pin    = pin_q;
  assign cmp_pin_lo = 1'b0;

  // R3: a full match is recorded in the high match flag
  a_r3_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
    match_full |=> flags_q[FLG_CMF_HI]);

  // R4: a match without a control write flips the pin
  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (match_full && !wr_ctrl) |=> cmp_pin != $past(cmp_pin));

  // R5: a control write sets the pin level, match or not
  a_r5_level_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> cmp_pin == $past(bus_wdata[CTL_LEVEL]));

  // R12: with run cleared the pin and counter do not move
  a_r12_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !bus_wr) |=> $stable(cmp_pin) && $stable(cnt_q));
endmodule

// File: tb/cmp_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_tick = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       cmp_pin, cmp_pin_lo;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_cnt, m_cmp;
  logic        m_run, m_level, m_out;
  logic [3:0]  m_flags, m_armed;

  always #10 clk = ~clk;

  cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_pin(cmp_pin), .cmp_pin_lo(cmp_pin_lo)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic check_state(input string tag);
    logic [7:0] v;
    peek(3'd0, v); chk(tag, "cnt_lo", {8'd0, v}, {8'd0, m_cnt[7:0]});
    peek(3'd1, v); chk(tag, "cnt_hi", {8'd0, v}, {8'd0, m_cnt[15:8]});
    peek(3'd2, v); chk(tag, "cmp_lo", {8'd0, v}, {8'd0, m_cmp[7:0]});
    peek(3'd3, v); chk(tag, "cmp_hi", {8'd0, v}, {8'd0, m_cmp[15:8]});
    peek(3'd4, v); chk(tag, "ctrl",   {8'd0, v}, {14'd0, m_run, m_level});
    peek(3'd5, v); chk(tag, "flags",  {8'd0, v}, {12'd0, m_flags});
    chk(tag, "cmp_pin", {15'd0, cmp_pin}, {15'd0, m_out});
    chk("R11", "cmp_pin_lo", {15'd0, cmp_pin_lo}, 16'd0);
  endtask

  // Reference model built from the requirement text
  function automatic void model_cycle(input logic t, input logic w, input logic r,
                                      input logic [2:0] a, input logic [7:0] d);
    logic        cnt_step, m_hi, m_lo, o_lo, o_hi;
    logic [15:0] nxt;
    logic [3:0]  clr;
    logic [3:0]  old_flags;
    cnt_step  = t && m_run;
    m_lo      = cnt_step && (m_cnt[7:0] == m_cmp[7:0]) && !(w && a == 3'd2);
    m_hi      = m_lo && (m_cnt[15:8] == m_cmp[15:8]);
    o_lo      = cnt_step && (m_cnt[7:0] == 8'hFF) && !(w && a == 3'd0);
    o_hi      = o_lo && (m_cnt[15:8] == 8'hFF);
    nxt       = m_cnt + (cnt_step ? 16'd1 : 16'd0);
    if (w && a == 3'd0) nxt = {m_cnt[15:8], d};
    if (w && a == 3'd1) nxt[15:8] = d;
    m_cnt     = nxt;
    if (w && a == 3'd2) m_cmp[7:0]  = d;
    if (w && a == 3'd3) m_cmp[15:8] = d;
    if (w && a == 3'd4) begin
      m_run = d[1]; m_level = d[0]; m_out = d[0];
    end else if (m_hi) begin
      m_out = ~m_out;
    end
    old_flags = m_flags;
    clr       = (w && a == 3'd5) ? (m_armed & ~d[3:0]) : 4'd0;
    m_flags   = {m_hi, m_lo, o_hi, o_lo} | (m_flags & ~clr);
    if (w && a == 3'd5)      m_armed = 4'd0;
    else if (r && a == 3'd5) m_armed = old_flags;
  endfunction

  task automatic cyc(input logic t, input logic w, input logic r, input logic [2:0] a,
                     input logic [7:0] d, input string tag);
    cnt_tick = t; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    model_cycle(t, w, r, a, d);
    @(posedge clk);
    @(negedge clk);
    cnt_tick = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    check_state(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    cyc(1'b0, 1'b1, 1'b0, a, d, tag);
  endtask

  task automatic tick(input string tag);
    cyc(1'b1, 1'b0, 1'b0, 3'd0, 8'd0, tag);
  endtask

  task automatic clear_all(input string tag);
    cyc(1'b0, 1'b0, 1'b1, 3'd5, 8'd0, tag);
    wr(3'd5, 8'h00, tag);
  endtask

  function automatic logic [7:0] pick_data();
    case ($urandom % 4)
      0:       return 8'hFF;
      1:       return 8'h00;
      2:       return 8'($urandom % 8);
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2718));
    m_cnt = 16'd0; m_cmp = 16'hFFFF; m_run = 1'b0; m_level = 1'b0; m_out = 1'b0;
    m_flags = 4'd0; m_armed = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_state("R1");

    // R2: run set in the same cycle as a tick does not count yet
    cyc(1'b1, 1'b1, 1'b0, 3'd4, 8'h02, "R2");
    repeat (3) tick("R2");
    peek(3'd0, v); chk("R2", "count after three ticks", {8'd0, v}, 16'd3);
    repeat (2) cyc(1'b0, 1'b0, 1'b0, 3'd0, 8'd0, "R2");

    // R12: stopped counter, compare equals counter, no match
    wr(3'd4, 8'h00, "R12");
    wr(3'd3, 8'h00, "R12");
    wr(3'd2, 8'h03, "R12");
    repeat (3) tick("R12");
    peek(3'd5, v); chk("R12", "flags while stopped", {8'd0, v}, 16'd0);

    // R3: arrival does not match, departure does
    wr(3'd4, 8'h02, "R3");
    wr(3'd0, 8'h01, "R3");
    tick("R3");
    tick("R3");
    peek(3'd5, v); chk("R3", "flag on arrival", {15'd0, v[3]}, 16'd0);
    tick("R3");
    peek(3'd5, v); chk("R3", "flag on departure", {15'd0, v[3]}, 16'd1);
    chk("R4", "pin toggled", {15'd0, cmp_pin}, 16'd1);

    // R5: control write in the match cycle overrides the toggle
    wr(3'd0, 8'h03, "R5");
    cyc(1'b1, 1'b1, 1'b0, 3'd4, 8'h03, "R5");
    chk("R5", "pin takes new level", {15'd0, cmp_pin}, 16'd1);

    // R10: write of 0 without a prior read leaves the flag
    wr(3'd5, 8'h00, "R10");
    peek(3'd5, v); chk("R10", "unarmed clear ignored", {8'd0, v}, {12'd0, m_flags});
    clear_all("R10");
    peek(3'd5, v); chk("R10", "armed clear", {8'd0, v}, 16'd0);

    // R6: compare-low write suppresses the match, new value matches later
    wr(3'd0, 8'h03, "R6");
    cyc(1'b1, 1'b1, 1'b0, 3'd2, 8'h04, "R6");
    peek(3'd5, v); chk("R6", "suppressed match", {8'd0, v}, 16'd0);
    tick("R6");
    peek(3'd5, v); chk("R6", "later match", {14'd0, v[3:2]}, 16'd3);
    chk("R6", "pin after later match", {15'd0, cmp_pin}, 16'd0);

    // R7: low-byte match only
    clear_all("R7");
    wr(3'd3, 8'h01, "R7");
    wr(3'd0, 8'h04, "R7");
    tick("R7");
    peek(3'd5, v); chk("R7", "low match only", {14'd0, v[3:2]}, 16'd1);

    // R8: low wrap, then full wrap
    clear_all("R8");
    wr(3'd0, 8'hFF, "R8");
    tick("R8");
    peek(3'd5, v); chk("R8", "low overflow", {14'd0, v[1:0]}, 16'd1);
    clear_all("R8");
    wr(3'd1, 8'hFF, "R8");
    wr(3'd0, 8'hFF, "R8");
    tick("R8");
    peek(3'd5, v); chk("R8", "full overflow", {14'd0, v[1:0]}, 16'd3);
    peek(3'd1, v); chk("R8", "wrapped high byte", {8'd0, v}, 16'd0);

    // R9: low counter write during a wrap tick
    clear_all("R9");
    wr(3'd1, 8'h12, "R9");
    wr(3'd0, 8'hFF, "R9");
    cyc(1'b1, 1'b1, 1'b0, 3'd0, 8'h10, "R9");
    peek(3'd1, v); chk("R9", "high byte holds", {8'd0, v}, 16'h0012);
    peek(3'd5, v); chk("R9", "no overflow", {14'd0, v[1:0]}, 16'd0);

    // R10: hardware set wins over an armed clear
    clear_all("R10");
    wr(3'd0, 8'hFF, "R10");
    tick("R10");
    cyc(1'b0, 1'b0, 1'b1, 3'd5, 8'd0, "R10");
    wr(3'd0, 8'hFF, "R10");
    cyc(1'b1, 1'b1, 1'b0, 3'd5, 8'h00, "R10");
    peek(3'd5, v); chk("R10", "set beats clear", {15'd0, v[0]}, 16'd1);

    // Random phase: all requirements against the model
    for (int i = 0; i < 4000; i++) begin
      logic       t, w, r;
      logic [2:0] a;
      logic [7:0] d;
      t = ($urandom % 10) < 7;
      w = ($urandom % 10) < 3;
      r = ($urandom % 10) < 2;
      a = 3'($urandom % 6);
      d = pick_data();
      if (w && a == 3'd4) d[1] = ($urandom % 5) != 0;
      if (r && !w) a = 3'd5;
      cyc(t, w, r, a, d, "rand");
    end

    finish_run();
  end
endmodule